// File: doc/BRIEF.md
# Sixteen-bit register-immediate execution core

The core runs a program from a read-only program port, one instruction at a time and without pipelining. Every instruction word is 32 bits and carries an 8-bit opcode, an 8-bit destination register index and a 16-bit data field. The data field is either an immediate operand or, in the register-register forms, holds the index of the second register in its low byte.

The core has no data memory. It holds twelve 16-bit registers. Indices 0 to 7 are general purpose. Index 8 is the pixel X coordinate and index 9 is the pixel Y coordinate. Index 10 holds the character code to print. Index 11 is kept for a compare result that a separate compare and branch unit would produce. All twelve registers can be loaded like any other register. Character output, pixel plotting and the draw-screen request leave the core as one-cycle strobes, each with its payload.

The control is a four-state machine:

- FETCH latches the word at `prog_addr` and always moves to EXEC.
- EXEC carries out the instruction. It moves to HALTED on halt. It moves to DIVIDE on a divide whose divisor is not zero. Otherwise it returns to FETCH.
- DIVIDE waits for the bit-serial divider and returns to FETCH when the quotient is ready.
- HALTED is left only by reset.

Top module: `imm16_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `prog_addr` is 0, `halted` is 0 and no strobe is high.
- R2: Opcode 0x20 loads the 16-bit data field into the register selected by bits 23:16. Opcode 0x10 copies the register whose index is in data bits 7:0 into that register.
- R3: Opcodes 0x30 and 0x31 add, and opcodes 0x40 and 0x41 subtract, an immediate (0x30, 0x40) or a register (0x31, 0x41). The result wraps modulo 2^16.
- R4: Opcodes 0x50 (immediate) and 0x51 (register) multiply and keep the low 16 bits of the product.
- R5: Opcodes 0x60 (immediate) and 0x61 (register) divide unsigned and drop the remainder. With a nonzero divisor the instruction takes 19 cycles from fetch to the next fetch.
- R6: A divide by zero leaves the destination register unchanged and takes 2 cycles.
- R7: Opcode 0xFF raises `char_valid` for one cycle, with `char_code` equal to bits 7:0 of register 10.
- R8: Opcode 0x0F raises `pix_valid` for one cycle, with `pix_x` from register 8, `pix_y` from register 9 and `pix_white` equal to data bit 0.
- R9: Opcode 0xDD raises `draw_strobe` for one cycle.
- R10: After opcode 0xFE, `halted` goes high and stays high until reset. `prog_addr` then stays at the address of the halt word.
- R11: Opcode 0x00 and any opcode not listed change no register and raise no strobe. The program address still advances.
- R12: A write to a register index of 12 or more is ignored and does not alias onto a lower register. Reading such an index as a source gives 0.
- R13: Each instruction other than a nonzero divide takes exactly 2 cycles, and the program address advances by one word per instruction.
- R14: Every strobe appears in the cycle after the instruction's execute cycle. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | 8 | Word address of the instruction to fetch |
| prog_data | input | 32 | Instruction word at `prog_addr`, valid in the same cycle |
| char_valid | output | 1 | One-cycle character output strobe |
| char_code | output | 8 | Character code sent with `char_valid` |
| pix_valid | output | 1 | One-cycle pixel write strobe |
| pix_x | output | 16 | Pixel X coordinate |
| pix_y | output | 16 | Pixel Y coordinate |
| pix_white | output | 1 | Pixel value: 1 is white, 0 is black |
| draw_strobe | output | 1 | One-cycle request to present the screen buffer |
| halted | output | 1 | High once a halt has executed |

## Verification
The bench targets wrap-around in add, subtract and multiply. A design that widened or saturated these results would plot the wrong coordinates. It runs divides by a zero register and by a zero immediate. A design that wrote the quotient anyway, or started the divider, would corrupt register 9 or lose 17 cycles. It writes to indices 12 and 0x18 and reads index 0x20. A design that truncated the index would overwrite register 8 or return a live value. It also checks that an unknown opcode acts as a no-op, and that after a halt the address freezes and no further instruction runs.

// File: rtl/imm16_pkg.sv
package imm16_pkg;

    localparam int INSN_W = 32;

    typedef enum logic [7:0] {
        OP_NOP   = 8'h00,
        OP_PIXEL = 8'h0F,
        OP_COPY  = 8'h10,
        OP_LOAD  = 8'h20,
        OP_ADDI  = 8'h30,
        OP_ADDR  = 8'h31,
        OP_SUBI  = 8'h40,
        OP_SUBR  = 8'h41,
        OP_MULI  = 8'h50,
        OP_MULR  = 8'h51,
        OP_DIVI  = 8'h60,
        OP_DIVR  = 8'h61,
        OP_DRAW  = 8'hDD,
        OP_HALT  = 8'hFE,
        OP_PRINT = 8'hFF
    } opcode_e;

    typedef enum logic [3:0] {
        K_NOP, K_MOVE, K_ADD, K_SUB, K_MUL, K_DIV,
        K_PRINT, K_PIXEL, K_DRAW, K_HALT
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  src_is_reg;
        logic  writes;
    } ctrl_t;

    typedef enum logic [1:0] {
        S_FETCH, S_EXEC, S_DIVIDE, S_HALTED
    } state_e;

endpackage

// File: rtl/imm16_decode.sv
module imm16_decode
    import imm16_pkg::*;
(
    input  logic [7:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{kind: K_NOP, src_is_reg: 1'b0, writes: 1'b0};
        case (opcode)
            OP_LOAD:  ctrl = '{kind: K_MOVE,  src_is_reg: 1'b0, writes: 1'b1};
            OP_COPY:  ctrl = '{kind: K_MOVE,  src_is_reg: 1'b1, writes: 1'b1};
            OP_ADDI:  ctrl = '{kind: K_ADD,   src_is_reg: 1'b0, writes: 1'b1};
            OP_ADDR:  ctrl = '{kind: K_ADD,   src_is_reg: 1'b1, writes: 1'b1};
            OP_SUBI:  ctrl = '{kind: K_SUB,   src_is_reg: 1'b0, writes: 1'b1};
            OP_SUBR:  ctrl = '{kind: K_SUB,   src_is_reg: 1'b1, writes: 1'b1};
            OP_MULI:  ctrl = '{kind: K_MUL,   src_is_reg: 1'b0, writes: 1'b1};
            OP_MULR:  ctrl = '{kind: K_MUL,   src_is_reg: 1'b1, writes: 1'b1};
            OP_DIVI:  ctrl = '{kind: K_DIV,   src_is_reg: 1'b0, writes: 1'b1};
            OP_DIVR:  ctrl = '{kind: K_DIV,   src_is_reg: 1'b1, writes: 1'b1};
            OP_PRINT: ctrl = '{kind: K_PRINT, src_is_reg: 1'b0, writes: 1'b0};
            OP_PIXEL: ctrl = '{kind: K_PIXEL, src_is_reg: 1'b0, writes: 1'b0};
            OP_DRAW:  ctrl = '{kind: K_DRAW,  src_is_reg: 1'b0, writes: 1'b0};
            OP_HALT:  ctrl = '{kind: K_HALT,  src_is_reg: 1'b0, writes: 1'b0};
            default:  ctrl = '{kind: K_NOP,   src_is_reg: 1'b0, writes: 1'b0};
        endcase
    end
endmodule

// File: rtl/imm16_alu.sv
module imm16_alu
    import imm16_pkg::*;
#(
    parameter int W = 16
) (
    input  kind_e          kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    always_comb begin
        unique case (kind)
            K_ADD:   y = a + b;
            K_SUB:   y = a - b;
            K_MUL:   y = a * b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/imm16_divider.sv
module imm16_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, quo_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [W:0]       shifted;
    logic             fits;

    assign shifted  = {rem_q, quo_q[W-1]};
    assign fits     = shifted >= {1'b0, den_q};
    assign done     = active_q && (cnt_q == '0);
    assign quotient = quo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            quo_q    <= '0;
            den_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            rem_q    <= '0;
            quo_q    <= dividend;
            den_q    <= divisor;
            cnt_q    <= CNT_W'(W);
            active_q <= 1'b1;
        end else if (active_q) begin
            if (cnt_q == '0) begin
                active_q <= 1'b0;
            end else begin
                rem_q <= fits ? W'(shifted - {1'b0, den_q}) : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // The remainder left over must be smaller than the divisor.
    assert_div_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q < den_q));
    // A divide is never started with a zero divisor.
    assert_no_zero_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (divisor != '0));
endmodule

// File: rtl/imm16_regfile.sv
module imm16_regfile #(
    parameter int W         = 16,
    parameter int NUM_REGS  = 12,
    parameter int IDX_X     = 8,
    parameter int IDX_Y     = 9,
    parameter int IDX_PRINT = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [7:0]   waddr,
    input  logic [W-1:0] wdata,
    input  logic [7:0]   raddr_a,
    input  logic [7:0]   raddr_b,
    output logic [W-1:0] rdata_a,
    output logic [W-1:0] rdata_b,
    output logic [W-1:0] x_val,
    output logic [W-1:0] y_val,
    output logic [7:0]   print_code
);
    localparam logic [7:0] LIMIT = 8'(NUM_REGS);

    logic [NUM_REGS-1:0][W-1:0] regs;
    logic [NUM_REGS-1:0]        hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = we && (waddr == 8'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (hit[i]) regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr_a == 8'(i)) rdata_a = regs[i];
            if (raddr_b == 8'(i)) rdata_b = regs[i];
        end
    end

    assign x_val      = regs[IDX_X];
    assign y_val      = regs[IDX_Y];
    assign print_code = regs[IDX_PRINT][7:0];

    // An out-of-range write index touches no register.
    assert_oob_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr >= LIMIT) |=> $stable(regs));
endmodule

// File: rtl/imm16_core.sv
module imm16_core
    import imm16_pkg::*;
#(
    parameter int W         = 16,
    parameter int PC_W      = 8,
    parameter int NUM_REGS  = 12,
    parameter int IDX_X     = 8,
    parameter int IDX_Y     = 9,
    parameter int IDX_PRINT = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] prog_addr,
    input  logic [31:0]     prog_data,
    output logic            char_valid,
    output logic [7:0]      char_code,
    output logic            pix_valid,
    output logic [W-1:0]    pix_x,
    output logic [W-1:0]    pix_y,
    output logic            pix_white,
    output logic            draw_strobe,
    output logic            halted
);
    state_e          state_q, state_d;
    logic [PC_W-1:0] pc_q;
    logic [31:0]     ir_q;
    ctrl_t           ctrl;

    logic [7:0]   f_op, f_rd;
    logic [15:0]  f_dat;
    logic [W-1:0] rdata_a, rdata_b, operand_b, alu_y, quotient;
    logic [W-1:0] x_val, y_val;
    logic [7:0]   print_code;
    logic         div_start, div_done, pc_step, rf_we;
    logic [W-1:0] rf_wdata;

    assign f_op  = ir_q[31:24];
    assign f_rd  = ir_q[23:16];
    assign f_dat = ir_q[15:0];

    imm16_decode u_dec (.opcode(f_op), .ctrl(ctrl));

    imm16_regfile #(.W(W), .NUM_REGS(NUM_REGS), .IDX_X(IDX_X),
                    .IDX_Y(IDX_Y), .IDX_PRINT(IDX_PRINT)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(f_rd), .wdata(rf_wdata),
        .raddr_a(f_rd), .raddr_b(f_dat[7:0]), .rdata_a(rdata_a),
        .rdata_b(rdata_b), .x_val(x_val), .y_val(y_val), .print_code(print_code)
    );

    assign operand_b = ctrl.src_is_reg ? rdata_b : W'(f_dat);

    imm16_alu #(.W(W)) u_alu (.kind(ctrl.kind), .a(rdata_a), .b(operand_b), .y(alu_y));

    imm16_divider #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(rdata_a),
        .divisor(operand_b), .done(div_done), .quotient(quotient)
    );

    assign div_start = (state_q == S_EXEC) && (ctrl.kind == K_DIV) && (operand_b != '0);
    assign pc_step   = ((state_q == S_EXEC) && (ctrl.kind != K_HALT) && !div_start)
                     || ((state_q == S_DIVIDE) && div_done);
    assign rf_we     = ((state_q == S_EXEC) && ctrl.writes && (ctrl.kind != K_DIV))
                     || ((state_q == S_DIVIDE) && div_done);
    assign rf_wdata  = (state_q == S_DIVIDE) ? quotient : alu_y;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH:  state_d = S_EXEC;
            S_EXEC: begin
                if (ctrl.kind == K_HALT) state_d = S_HALTED;
                else if (div_start)      state_d = S_DIVIDE;
                else                     state_d = S_FETCH;
            end
            S_DIVIDE: if (div_done) state_d = S_FETCH;
            S_HALTED: state_d = S_HALTED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // Program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (state_q == S_FETCH) ir_q <= prog_data;
            if (pc_step)            pc_q <= pc_q + 1'b1;
        end
    end

    // Strobed outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_valid  <= 1'b0;
            char_code   <= '0;
            pix_valid   <= 1'b0;
            pix_x       <= '0;
            pix_y       <= '0;
            pix_white   <= 1'b0;
            draw_strobe <= 1'b0;
        end else begin
            char_valid  <= 1'b0;
            pix_valid   <= 1'b0;
            draw_strobe <= 1'b0;
            if (state_q == S_EXEC) begin
                unique case (ctrl.kind)
                    K_PRINT: begin
                        char_valid <= 1'b1;
                        char_code  <= print_code;
                    end
                    K_PIXEL: begin
                        pix_valid <= 1'b1;
                        pix_x     <= x_val;
                        pix_y     <= y_val;
                        pix_white <= f_dat[0];
                    end
                    K_DRAW:  draw_strobe <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign prog_addr = pc_q;
    assign halted    = (state_q == S_HALTED);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_pc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(prog_addr));
    assert_pc_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && ctrl.kind != K_HALT && !div_start)
        |=> prog_addr == $past(prog_addr) + PC_W'(1));
    assert_one_strobe_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({char_valid, pix_valid, draw_strobe}));
    assert_draw_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        draw_strobe |=> !draw_strobe);
    assert_no_strobe_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> !(char_valid || pix_valid || draw_strobe));
endmodule

// File: tb/sim_imm16_core.sv
`timescale 1ns/1ps
module sim_imm16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  prog_addr;
    logic [31:0] prog_data;
    logic        char_valid, pix_valid, pix_white, draw_strobe, halted;
    logic [7:0]  char_code;
    logic [15:0] pix_x, pix_y;

    always #2.5 clk = ~clk;

    logic [31:0] rom [64];
    string       rtag [64];
    int          n_checks = 0;
    int          n_fail = 0;

    assign prog_data = (prog_addr < 8'd64) ? rom[prog_addr[5:0]] : 32'h0;

    imm16_core u0 (
        .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
        .char_valid(char_valid), .char_code(char_code), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_white(pix_white),
        .draw_strobe(draw_strobe), .halted(halted)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [7:0] op, input logic [7:0] rd,
                       input logic [15:0] d, input string t);
        rom[a]  = {op, rd, d};
        rtag[a] = t;
    endtask

    // Behavioural reference model
    int          m_pc = 0;
    int          m_cyc = 0;
    bit          m_halt = 0;
    logic [15:0] m_r [12];
    bit          e_char, e_pix, e_draw, e_white;
    logic [7:0]  e_code;
    logic [15:0] e_x, e_y;
    string       e_tag = "R14";

    function automatic logic [15:0] rreg(input int i);
        return (i < 12) ? m_r[i] : 16'h0;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            e_char = 0; e_pix = 0; e_draw = 0;
            if (!m_halt) begin
                logic [31:0] w;
                logic [7:0]  op;
                int          rd, lat;
                logic [15:0] a, b, res;
                bit          wr;
                w  = rom[m_pc];
                op = w[31:24];
                rd = int'(w[23:16]);
                a  = rreg(rd);
                b  = op[0] ? rreg(int'(w[7:0])) : w[15:0];
                if (op == 8'h10) b = rreg(int'(w[7:0]));
                if (op == 8'h20) b = w[15:0];
                lat = ((op == 8'h60 || op == 8'h61) && b != 0) ? 19 : 2;
                m_cyc++;
                if (m_cyc == lat) begin
                    m_cyc = 0;
                    wr = 1;
                    res = 16'h0;
                    case (op)
                        8'h10, 8'h20: res = b;
                        8'h30, 8'h31: res = a + b;
                        8'h40, 8'h41: res = a - b;
                        8'h50, 8'h51: res = a * b;
                        8'h60, 8'h61: if (b != 0) res = a / b; else wr = 0;
                        default: wr = 0;
                    endcase
                    if (wr && rd < 12) m_r[rd] = res;
                    e_tag = rtag[m_pc];
                    case (op)
                        8'hFF: begin e_char = 1; e_code = m_r[10][7:0]; end
                        8'h0F: begin e_pix = 1; e_x = m_r[8]; e_y = m_r[9]; e_white = w[0]; end
                        8'hDD: e_draw = 1;
                        default: ;
                    endcase
                    if (op == 8'hFE) m_halt = 1;
                    else m_pc++;
                end
            end
        end
    end

    initial begin
        int post_halt;
        int cycles;
        for (int i = 0; i < 64; i++) begin rom[i] = 32'h0; rtag[i] = "R11"; end
        for (int i = 0; i < 12; i++) m_r[i] = 16'h0;
        put(0,  8'h20, 8'h01, 16'h1234, "R2");
        put(1,  8'h10, 8'h08, 16'h0001, "R2");
        put(2,  8'h20, 8'h09, 16'h00AB, "R2");
        put(3,  8'h0F, 8'h00, 16'h0001, "R2");   // x=1234 y=00AB
        put(4,  8'h30, 8'h08, 16'hFFFF, "R3");
        put(5,  8'h0F, 8'h00, 16'h0000, "R3");   // x=1233 wraps
        put(6,  8'h20, 8'h02, 16'h0002, "R3");
        put(7,  8'h41, 8'h08, 16'h0002, "R3");
        put(8,  8'h40, 8'h09, 16'h00AC, "R3");
        put(9,  8'h0F, 8'h00, 16'h0001, "R3");   // x=1231 y=FFFF
        put(10, 8'h31, 8'h09, 16'h0008, "R3");
        put(11, 8'h50, 8'h08, 16'h0100, "R4");
        put(12, 8'h0F, 8'h00, 16'h0001, "R4");   // x=3100 y=1230
        put(13, 8'h51, 8'h09, 16'h0002, "R4");
        put(14, 8'h60, 8'h09, 16'h0007, "R5");
        put(15, 8'h0F, 8'h00, 16'h0001, "R5");   // y=0532
        put(16, 8'h20, 8'h03, 16'h0000, "R6");
        put(17, 8'h61, 8'h09, 16'h0003, "R6");
        put(18, 8'h60, 8'h08, 16'h0000, "R6");
        put(19, 8'h0F, 8'h00, 16'h0000, "R6");
        put(20, 8'h61, 8'h08, 16'h0002, "R5");
        put(21, 8'h20, 8'h0A, 16'h0068, "R7");
        put(22, 8'hFF, 8'h00, 16'h0000, "R7");
        put(23, 8'h20, 8'h0A, 16'h4167, "R7");
        put(24, 8'hFF, 8'h00, 16'h0000, "R7");
        put(25, 8'h20, 8'h18, 16'h7777, "R12");
        put(26, 8'h20, 8'h0C, 16'h5555, "R12");
        put(27, 8'h0F, 8'h00, 16'h0001, "R12");  // x unchanged by 0x18
        put(28, 8'h10, 8'h09, 16'h0020, "R12");
        put(29, 8'h0F, 8'h00, 16'h0000, "R12");  // y=0
        put(30, 8'h77, 8'h08, 16'h0000, "R11");
        put(31, 8'h00, 8'h09, 16'h1111, "R11");
        put(32, 8'h0F, 8'h00, 16'h0001, "R11");
        put(33, 8'h20, 8'h0A, 16'h0021, "R8");
        put(34, 8'h0F, 8'h00, 16'h0000, "R8");
        put(35, 8'hDD, 8'h00, 16'h0000, "R9");
        put(36, 8'hFE, 8'h00, 16'h0000, "R10");
        put(37, 8'h20, 8'h0A, 16'h0058, "R10");
        put(38, 8'hFF, 8'h00, 16'h0000, "R10");

        repeat (3) @(negedge clk);
        chk(prog_addr == 8'd0, "R1", "prog_addr in reset", prog_addr, 0);
        chk(!halted, "R1", "halted in reset", halted, 0);
        chk(!(char_valid | pix_valid | draw_strobe), "R1", "strobes in reset",
            {char_valid, pix_valid, draw_strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prog_addr == 8'd0 && !halted, "R1", "first cycle after reset",
            {halted, prog_addr}, 0);

        post_halt = 0;
        cycles = 0;
        while (post_halt < 20 && cycles < 3000) begin
            @(negedge clk);
            cycles++;
            chk(prog_addr == 8'(m_pc), "R13", "prog_addr", prog_addr, m_pc);
            chk(halted == m_halt, "R10", "halted", halted, m_halt);
            chk(char_valid == e_char, "R14", "char_valid timing", char_valid, e_char);
            chk(pix_valid == e_pix, "R14", "pix_valid timing", pix_valid, e_pix);
            chk(draw_strobe == e_draw, e_tag, "draw_strobe", draw_strobe, e_draw);
            if (e_char && char_valid) begin
                chk(char_code == e_code, e_tag, "char_code", char_code, e_code);
                chk(char_code == e_code, "R7", "printed code", char_code, e_code);
            end
            if (e_pix && pix_valid) begin
                chk(pix_x == e_x, e_tag, "pix_x", pix_x, e_x);
                chk(pix_y == e_y, e_tag, "pix_y", pix_y, e_y);
                chk(pix_white == e_white, "R8", "pix_white", pix_white, e_white);
            end
            if (m_halt) post_halt++;
        end
        if (cycles >= 3000) chk(1'b0, "R10", "watchdog expired", cycles, 3000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule